// File: doc/BRIEF.md
# Cycle Counter with Postscaled Event Generator

This block keeps a free-running 32-bit cycle count and turns it into three periodic single-cycle pulses for a profiling unit. A low-order bit of the count (bit 6 or bit 10) steps a 4-bit postscale counter. When that counter runs past zero it reloads from a preset and raises a cycle-event pulse, a PC-sample request pulse, or both, depending on two enable bits. A second, independent pulse marks synchronization points: it fires whenever the count carries into one of three high-order bits, or never.

Software programs the block through one write port. A select input steers each write to either the control word or the count itself. A read mux, also steered by a select input, returns either of the two. The postscale counter's starting value can be loaded only while neither of its two consumers is enabled. This prevents a running event stream from being disturbed by a stray load.

The postscaler is built as a three-state machine. **HALT** means neither consumer is enabled, so tap steps are ignored. **WAIT** means it is counting down on each tap step. **FIRE** is the single cycle in which the pulses of an underflow are driven. The transitions are as follows. *arm* takes HALT to WAIT when an enable is set. *disarm* takes WAIT or FIRE to HALT when both enables are clear. *underflow* takes any state to FIRE when a tap step arrives at zero. *resume* takes FIRE back to WAIT on the following cycle.

Top module: `cyc_evt_gen`

## Requirements
- R1: After reset the control word and the count both read zero, the postscale counter holds zero, the state is HALT and no pulse output is high.
- R2: The count advances by one per clock only while control bit 0 is set. It wraps from 0xFFFFFFFF to 0. A write with `wr_sel`=1 replaces the count and takes the place of that cycle's increment.
- R3: With `rd_sel`=0, `rd_data` returns the control word: bit 0 is the count enable, bits 4:1 are the preset, bits 8:5 are the initial value, bit 9 is the postscale tap select, bits 11:10 are the sync select, bit 12 is the PC-sample enable and bit 22 is the cycle-event enable. Every other bit, including 15:13, reads zero and ignores writes. With `rd_sel`=1, `rd_data` returns the count.
- R4: A postscale tap step happens on a clock edge where the count increments with a carry into bit 6 (tap select 0) or into bit 10 (tap select 1). That is one step every 64 or 1024 counts.
- R5: While bit 12 or bit 22 is set, each tap step decrements the postscale counter. A step that finds the counter at zero is an underflow, and it reloads the counter from the preset.
- R6: A control write accepted while bits 12 and 22 were both clear stores bits 8:5 and loads them into the postscale counter. While either bit was set, the field and the counter are left unchanged.
- R7: An underflow drives `cyc_evt_o` high for exactly the next cycle if bit 22 was set, and `pc_sample_o` high for exactly the next cycle if bit 12 was set.
- R8: Sync select 0 produces no sync pulse. Select 1, 2 and 3 drive `sync_o` high for one cycle after an increment carries into count bit 24, 26 or 28 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 control word, 1 count |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read source: 0 control word, 1 count |
| rd_data | output | 32 | Read data |
| cyc_evt_o | output | 1 | Cycle-event pulse |
| pc_sample_o | output | 1 | PC-sample request pulse |
| sync_o | output | 1 | Synchronization request pulse |

## Verification
The postscale value cannot be read, so an error in it shows up only as a pulse that is early, late or missing. A wrong value therefore takes up to (preset+1) tap periods to surface: up to 16 × 1024 cycles. The bench keeps the cycle-exact expected pulse train and the read data, and compares them on every clock. Directed runs then count pulses over windows whose length is known. A fault in the count, by contrast, is visible on `rd_data` in the very next cycle.

// File: rtl/cyc_evt_pkg.sv
package cyc_evt_pkg;
    localparam int CNT_W  = 32;
    localparam int CTRL_W = 32;
    localparam int PS_W   = 4;

    // control word bit positions (decoded by software, kept fixed)
    localparam int B_EN      = 0;
    localparam int B_PRE_LO  = 1;
    localparam int B_INIT_LO = 5;
    localparam int B_TAPSEL  = 9;
    localparam int B_SYNC_LO = 10;
    localparam int B_PCS     = 12;
    localparam int B_CEV     = 22;

    // tap positions on the count
    localparam int PS_TAP_FAST   = 6;
    localparam int PS_TAP_SLOW   = 10;
    localparam int SYNC_TAP_BASE = 24;
    localparam int SYNC_TAP_STEP = 2;

    typedef struct packed {
        logic            cev_en;
        logic            pcs_en;
        logic [1:0]      sync_sel;
        logic            tap_sel;
        logic [PS_W-1:0] init;
        logic [PS_W-1:0] preset;
        logic            cnt_en;
    } ctrl_t;

    typedef enum logic [1:0] {
        PS_HALT = 2'd0,
        PS_WAIT = 2'd1,
        PS_FIRE = 2'd2
    } ps_state_e;
endpackage

// File: rtl/cyc_ctrl_reg.sv
module cyc_ctrl_reg
    import cyc_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output logic              cnt_en,
    output logic [PS_W-1:0]   preset,
    output logic              tap_sel,
    output logic [1:0]        sync_sel,
    output logic              pcs_en,
    output logic              cev_en,
    output logic              init_load,
    output logic [PS_W-1:0]   init_val,
    output logic [CTRL_W-1:0] rdata
);
    ctrl_t ctrl_q;
    logic  guard;
    logic  wdata_unused;

    assign guard        = ctrl_q.cev_en | ctrl_q.pcs_en;
    assign init_load    = we && !guard;
    assign init_val     = wdata[B_INIT_LO +: PS_W];
    assign wdata_unused = ^{wdata[CTRL_W-1:B_CEV+1], wdata[B_CEV-1:B_PCS+1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (we) begin
            ctrl_q.cnt_en   <= wdata[B_EN];
            ctrl_q.preset   <= wdata[B_PRE_LO +: PS_W];
            ctrl_q.tap_sel  <= wdata[B_TAPSEL];
            ctrl_q.sync_sel <= wdata[B_SYNC_LO +: 2];
            ctrl_q.pcs_en   <= wdata[B_PCS];
            ctrl_q.cev_en   <= wdata[B_CEV];
            if (!guard) ctrl_q.init <= wdata[B_INIT_LO +: PS_W];
        end
    end

    always_comb begin
        rdata                        = '0;
        rdata[B_EN]                  = ctrl_q.cnt_en;
        rdata[B_PRE_LO +: PS_W]      = ctrl_q.preset;
        rdata[B_INIT_LO +: PS_W]     = ctrl_q.init;
        rdata[B_TAPSEL]              = ctrl_q.tap_sel;
        rdata[B_SYNC_LO +: 2]        = ctrl_q.sync_sel;
        rdata[B_PCS]                 = ctrl_q.pcs_en;
        rdata[B_CEV]                 = ctrl_q.cev_en;
    end

    assign cnt_en   = ctrl_q.cnt_en;
    assign preset   = ctrl_q.preset;
    assign tap_sel  = ctrl_q.tap_sel;
    assign sync_sel = ctrl_q.sync_sel;
    assign pcs_en   = ctrl_q.pcs_en;
    assign cev_en   = ctrl_q.cev_en;

    // R6
    init_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && guard) |=> $stable(rdata[B_INIT_LO +: PS_W]));
endmodule

// File: rtl/cyc_counter.sv
module cyc_counter
    import cyc_evt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic         tap_sel,
    input  logic [1:0]   sync_sel,
    output logic [W-1:0] count,
    output logic         ps_tick,
    output logic         sync_tick
);
    logic         step;
    int           ps_pos;
    int           sync_pos;
    logic [W-1:0] ps_mask;
    logic [W-1:0] sync_mask;

    assign step = en && !we;

    always_comb begin
        ps_pos    = tap_sel ? PS_TAP_SLOW : PS_TAP_FAST;
        sync_pos  = SYNC_TAP_BASE + SYNC_TAP_STEP * (int'(sync_sel) - 1);
        ps_mask   = (W'(1) << ps_pos) - W'(1);
        sync_mask = (W'(1) << sync_pos) - W'(1);
        ps_tick   = step && ((count & ps_mask) == ps_mask);
        sync_tick = step && (sync_sel != 2'd0) && ((count & sync_mask) == sync_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    count <= '0;
        else if (we)   count <= wdata;
        else if (en)   count <= count + W'(1);
    end

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !we) |=> $stable(count));
    // R2
    count_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !we) |=> (count == $past(count) + W'(1)));
endmodule

// File: rtl/cyc_postscaler.sv
module cyc_postscaler
    import cyc_evt_pkg::*;
#(
    parameter int W = PS_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         cev_en,
    input  logic         pcs_en,
    input  logic [W-1:0] preset,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         cev_pulse,
    output logic         pcs_pulse
);
    ps_state_e    state_q, state_d;
    logic [W-1:0] post_q;
    logic [1:0]   kind_q;
    logic         run, under;

    assign run   = cev_en | pcs_en;
    assign under = run && tick && (post_q == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_HALT: if (under) state_d = PS_FIRE;
                     else if (run) state_d = PS_WAIT;
            PS_WAIT: if (under) state_d = PS_FIRE;
                     else if (!run) state_d = PS_HALT;
            PS_FIRE: if (under) state_d = PS_FIRE;
                     else if (run) state_d = PS_WAIT;
                     else state_d = PS_HALT;
            default: state_d = PS_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_HALT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            post_q <= '0;
            kind_q <= '0;
        end else begin
            if (load)             post_q <= load_val;
            else if (under)       post_q <= preset;
            else if (run && tick) post_q <= post_q - W'(1);
            if (under)            kind_q <= {cev_en, pcs_en};
        end
    end

    always_comb begin
        cev_pulse = (state_q == PS_FIRE) && kind_q[1];
        pcs_pulse = (state_q == PS_FIRE) && kind_q[0];
    end

    // R5
    decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && post_q != '0 && !load) |=> (post_q == $past(post_q) - W'(1)));
    // R5
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (under && !load) |=> (post_q == $past(preset)));
    // R7
    cev_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cev_pulse |=> !cev_pulse);
    // R7
    pcs_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pcs_pulse |-> $past(pcs_en));
endmodule

// File: rtl/cyc_evt_gen.sv
module cyc_evt_gen
    import cyc_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [CTRL_W-1:0] rd_data,
    output logic              cyc_evt_o,
    output logic              pc_sample_o,
    output logic              sync_o
);
    logic              cnt_en, tap_sel, pcs_en, cev_en, init_load;
    logic [1:0]        sync_sel;
    logic [PS_W-1:0]   preset, init_val;
    logic [CTRL_W-1:0] ctrl_rdata;
    logic [CNT_W-1:0]  count;
    logic              ps_tick, sync_tick, sync_q;

    cyc_ctrl_reg u_ctrl (
        .clk(clk), .rst_n(rst_n), .we(wr_en && !wr_sel), .wdata(wr_data),
        .cnt_en(cnt_en), .preset(preset), .tap_sel(tap_sel), .sync_sel(sync_sel),
        .pcs_en(pcs_en), .cev_en(cev_en), .init_load(init_load),
        .init_val(init_val), .rdata(ctrl_rdata)
    );

    cyc_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(cnt_en), .we(wr_en && wr_sel),
        .wdata(wr_data[CNT_W-1:0]), .tap_sel(tap_sel), .sync_sel(sync_sel),
        .count(count), .ps_tick(ps_tick), .sync_tick(sync_tick)
    );

    cyc_postscaler #(.W(PS_W)) u_ps (
        .clk(clk), .rst_n(rst_n), .tick(ps_tick), .cev_en(cev_en), .pcs_en(pcs_en),
        .preset(preset), .load(init_load), .load_val(init_val),
        .cev_pulse(cyc_evt_o), .pcs_pulse(pc_sample_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= sync_tick;
    end

    assign sync_o  = sync_q;
    assign rd_data = rd_sel ? count : ctrl_rdata;

    // R8
    sync_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_sel == 2'd0) |=> !sync_o);
    // R8
    sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |=> !sync_o);
endmodule

// File: tb/cyc_evt_gen_test.sv
module cyc_evt_gen_test;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
    logic [31:0] wr_data = '0;
    wire  [31:0] rd_data;
    wire         cev, pcs, syn;

    cyc_evt_gen uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .cyc_evt_o(cev), .pc_sample_o(pcs), .sync_o(syn)
    );

    always #10 clk = ~clk;

    int n_run = 0, n_fail = 0, cyc = 0;
    int n_cev = 0, n_pcs = 0, n_syn = 0;

    // behavioural reference state
    logic [31:0] m_cnt = '0;
    logic [3:0]  m_pre = '0, m_init = '0, m_post = '0;
    logic [1:0]  m_sync = '0;
    logic        m_en = 0, m_tap = 0, m_pcs = 0, m_cev = 0;
    logic        e_cev = 0, e_pcs = 0, e_syn = 0;
    logic        cw, kw, step, ptk, stk, run;

    function automatic logic crossed(input logic [31:0] v, input int pos);
        logic [31:0] d;
        d = v ^ (v + 32'd1);
        return d[pos];
    endfunction

    function automatic logic [31:0] m_ctrl();
        logic [31:0] r;
        r = '0;
        r[0] = m_en; r[4:1] = m_pre; r[8:5] = m_init; r[9] = m_tap;
        r[11:10] = m_sync; r[12] = m_pcs; r[22] = m_cev;
        return r;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = '0; m_pre = '0; m_init = '0; m_post = '0; m_sync = '0;
            m_en = 0; m_tap = 0; m_pcs = 0; m_cev = 0;
            e_cev = 0; e_pcs = 0; e_syn = 0;
        end else begin
            cw   = wr_en && !wr_sel;
            kw   = wr_en && wr_sel;
            step = m_en && !kw;
            ptk  = step && crossed(m_cnt, m_tap ? 10 : 6);
            stk  = step && (m_sync != 0) && crossed(m_cnt, 22 + 2 * int'(m_sync));
            run  = m_cev | m_pcs;
            e_cev = ptk && run && (m_post == 0) && m_cev;
            e_pcs = ptk && run && (m_post == 0) && m_pcs;
            e_syn = stk;
            if (cw && !run)      m_post = wr_data[8:5];
            else if (ptk && run) m_post = (m_post == 0) ? m_pre : m_post - 4'd1;
            if (cw) begin
                m_en = wr_data[0]; m_pre = wr_data[4:1];
                if (!run) m_init = wr_data[8:5];
                m_tap = wr_data[9]; m_sync = wr_data[11:10];
                m_pcs = wr_data[12]; m_cev = wr_data[22];
            end
            if (kw)        m_cnt = wr_data;
            else if (step) m_cnt = m_cnt + 32'd1;
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (rd_sel) chk(rd_data === m_cnt, "R2 count value", rd_data, m_cnt);
            else        chk(rd_data === m_ctrl(), "R3 control readback", rd_data, m_ctrl());
            chk(cev === e_cev, "R7 cycle-event pulse", {31'd0, cev}, {31'd0, e_cev});
            chk(pcs === e_pcs, "R7 pc-sample pulse", {31'd0, pcs}, {31'd0, e_pcs});
            chk(syn === e_syn, "R8 sync pulse", {31'd0, syn}, {31'd0, e_syn});
            if (cev === 1'b1) n_cev++;
            if (pcs === 1'b1) n_pcs++;
            if (syn === 1'b1) n_syn++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clr_counts();
        n_cev = 0; n_pcs = 0; n_syn = 0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #5;
    endtask

    // stop everything, then program a quiet config with a given init/preset/tap
    task automatic quiet(input logic [31:0] cfg);
        wr(1'b0, 32'h0);
        wr(1'b0, cfg);
    endtask

    initial begin
        // R1: reset state
        #1;
        rd_sel = 1'b0; #1;
        chk(rd_data === 32'h0, "R1 control after reset", rd_data, 32'h0);
        rd_sel = 1'b1; #1;
        chk(rd_data === 32'h0, "R1 count after reset", rd_data, 32'h0);
        chk({cev, pcs, syn} === 3'b000, "R1 pulses after reset", {29'd0, cev, pcs, syn}, 32'h0);
        rd_sel = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3: readback mask of an all-ones write
        wr(1'b0, 32'hFFFF_FFFF);
        #3;
        chk(rd_data === 32'h0040_1FFF, "R3 reserved bits read zero", rd_data, 32'h0040_1FFF);

        // R2: wrap of the count
        quiet(32'h0000_0001);
        wr(1'b1, 32'hFFFF_FFFE);
        rd_sel = 1'b1; #1;
        chk(rd_data === 32'hFFFF_FFFE, "R2 direct count write", rd_data, 32'hFFFF_FFFE);
        @(negedge clk); #1;
        chk(rd_data === 32'hFFFF_FFFF, "R2 increment", rd_data, 32'hFFFF_FFFF);
        @(negedge clk); #1;
        chk(rd_data === 32'h0, "R2 wrap to zero", rd_data, 32'h0);

        // R2: disabled count holds
        wr(1'b0, 32'h0);
        #1;
        begin
            logic [31:0] held;
            held = rd_data;
            wait_cyc(100);
            chk(rd_data === held, "R2 hold while disabled", rd_data, held);
        end
        rd_sel = 1'b0;

        // R4 R5 R7: tap bit 6, preset 2, cycle events only -> underflow every 3 steps
        quiet(32'h0000_0004);
        wr(1'b1, 32'h0);
        wr(1'b0, 32'h0040_0005);
        clr_counts();
        wait_cyc(600);
        chk(n_cev == 3, "R5 cycle-event count, tap 6 preset 2", n_cev, 3);
        chk(n_pcs == 0, "R7 no pc-sample when disabled", n_pcs, 0);

        // R4 R7: tap bit 10, preset 0, pc-sample only
        quiet(32'h0000_0200);
        wr(1'b1, 32'h0);
        wr(1'b0, 32'h0000_1201);
        clr_counts();
        wait_cyc(3172);
        chk(n_pcs == 3, "R4 pc-sample count, tap 10", n_pcs, 3);
        chk(n_cev == 0, "R7 no cycle-event when disabled", n_cev, 0);

        // R6: initial value 5, preset 1: first underflow on the sixth step
        quiet(32'h0000_00A2);
        wr(1'b1, 32'h0);
        wr(1'b0, 32'h0040_00A3);
        clr_counts();
        wait_cyc(370);
        chk(n_cev == 0, "R6 no underflow before initial value drains", n_cev, 0);
        wait_cyc(30);
        chk(n_cev == 1, "R6 underflow after initial value drains", n_cev, 1);

        // R6: guarded write leaves the initial-value field alone
        wr(1'b0, 32'h0040_0003);
        #3;
        chk(rd_data === 32'h0040_00A3, "R6 guarded initial-value write ignored", rd_data, 32'h0040_00A3);

        // R8: sync tap selects
        wr(1'b0, 32'h0000_0401);
        wr(1'b1, 32'h00FF_FF00);
        clr_counts();
        wait_cyc(300);
        chk(n_syn == 1, "R8 sync at bit 24", n_syn, 1);

        wr(1'b0, 32'h0000_0001);
        wr(1'b1, 32'h00FF_FF00);
        clr_counts();
        wait_cyc(300);
        chk(n_syn == 0, "R8 sync disabled", n_syn, 0);

        wr(1'b0, 32'h0000_0C01);
        wr(1'b1, 32'h00FF_FF00);
        clr_counts();
        wait_cyc(300);
        chk(n_syn == 0, "R8 bit 24 carry ignored at select 3", n_syn, 0);

        wr(1'b1, 32'h0FFF_FF00);
        clr_counts();
        wait_cyc(300);
        chk(n_syn == 1, "R8 sync at bit 28", n_syn, 1);

        wr(1'b0, 32'h0000_0801);
        wr(1'b1, 32'h03FF_FF00);
        clr_counts();
        wait_cyc(300);
        chk(n_syn == 1, "R8 sync at bit 26", n_syn, 1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule